// File: doc/BRIEF.md
# Child Message Product Combiner

This block sits in one node of a tree-structured belief-propagation processor. It collects the per-element diagnostic vectors sent up by the node's children and returns one causal vector to each child. Each child vector is fetched exactly once over a single read bus that all children share. The value is copied into a local store, and every later use reads that copy.

After the load, the block forms the internal diagnostic vector as the element-wise product of all children's vectors. It then serves each child in turn with the same hardware. For a given child it multiplies the node's internal causal vector element by element with the messages of every other child, leaving out the child's own message. It sums the result over the vector, then divides each element by that sum so that the outgoing vector adds up to one. All values are unsigned fixed point. Products keep their full width. The sum is formed in a first pass. A second pass recomputes each product and feeds it to a sequential divider, waiting on that divider's handshake.

Addresses come from counters because every vector is walked in order. A start pulse launches the whole sequence. A done flag rises after the last outgoing element has been written and stays high until the next start.

Top module: `child_msg_combiner`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `done`, `lam_we`, `out_we` and `child_rd_en` are low.
- R2: During one run every element of every child vector is requested exactly once on the shared bus (`child_sel` below NCHILD, `child_addr` below VLEN), and the bus is idle while results are being written.
- R3: For each element address e, `lam_data` written at `lam_addr`=e equals the full-width unsigned product of all NCHILD children's element e, with no truncation.
- R4: For child i and element e, `out_data` equals floor(P_i[e]·2^FB / S_i). P_i[e] is the causal element e (`pi_data` at `pi_addr`=e) times the element e of every child except i. S_i is the sum of P_i over all elements.
- R5: Outgoing elements are written for child 0 first and child NCHILD-1 last, each child's elements in increasing address order from 0 to VLEN-1.
- R6: `done` falls on the cycle after an accepted start, stays low while results are written, and rises one cycle after the last element of child NCHILD-1 is written.
- R7: When S_i is zero, every element written for child i is zero.
- R8: When S_i is nonzero, the elements written for child i sum to between 2^FB−VLEN and 2^FB.
- R9: A start pulse that arrives while a run is in progress is ignored: no extra bus reads occur and the results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches a run when idle |
| child_rd_en | output | 1 | Read request on the shared child bus |
| child_sel | output | $clog2(NCHILD) | Child being read |
| child_addr | output | $clog2(VLEN) | Element being read |
| child_data | input | W | Child element, valid one cycle after the request |
| pi_rd_en | output | 1 | Read request for the internal causal vector |
| pi_addr | output | $clog2(VLEN) | Causal element address |
| pi_data | input | W | Causal element, valid one cycle after the request |
| lam_we | output | 1 | Write strobe for the internal diagnostic vector |
| lam_addr | output | $clog2(VLEN) | Diagnostic element address |
| lam_data | output | W·NCHILD | Diagnostic element (full-width product) |
| out_we | output | 1 | Write strobe for an outgoing causal element |
| out_child | output | $clog2(NCHILD) | Target child of the outgoing element |
| out_addr | output | $clog2(VLEN) | Outgoing element address |
| out_data | output | FB+1 | Normalized element, FB fraction bits |
| done | output | 1 | Run complete; held until the next start |

## Verification
The bound checker watches the block on every cycle. It checks that the bus select stays in range and that the bus never overlaps a result write. It also checks that outgoing writes follow the child-then-address order, that done stays low during writes, and that done rises only right after the final element. The arithmetic cannot be seen cycle by cycle and is left to the bench scenarios. Those scenarios cover the full-width diagnostic product, the exclude-one products, the normalized quotients and their sum bound, and zero sums. They also cover read-once counting and a start pulse injected mid-run, using random vectors and saturated, zero-child and zero-causal corner cases.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DIAG,
    ST_SUM,
    ST_DIVT,
    ST_DWAIT,
    ST_FIN
  } cmb_state_e;
endpackage

// File: rtl/cmb_store.sv
module cmb_store #(
  parameter int W     = 4,
  parameter int DEPTH = 32,
  parameter int AB    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AB-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AB-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmb_div.sv
module cmb_div #(
  parameter int NW = 24,
  parameter int DW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          ok,
  output logic [NW-1:0] quo
);
  localparam int CNTW = $clog2(NW + 1);

  logic            busy;
  logic [CNTW-1:0] cnt;
  logic [NW-1:0]   nsh;
  logic [DW:0]     rem;
  logic [DW-1:0]   den_r;
  logic [DW:0]     trial;
  logic            ge;

  assign trial = {rem[DW-1:0], nsh[NW-1]};
  assign ge    = trial >= {1'b0, den_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ok   <= 1'b0;
      cnt  <= '0;
      nsh  <= '0;
      rem  <= '0;
      quo  <= '0;
      den_r <= '0;
    end else begin
      ok <= 1'b0;
      if (go) begin
        busy  <= 1'b1;
        cnt   <= CNTW'(NW);
        nsh   <= num;
        rem   <= '0;
        quo   <= '0;
        den_r <= den;
      end else if (busy) begin
        rem <= ge ? (trial - {1'b0, den_r}) : trial;
        quo <= {quo[NW-2:0], ge};
        nsh <= nsh << 1;
        cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1)) begin
          busy <= 1'b0;
          ok   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/child_msg_combiner.sv
module child_msg_combiner #(
  parameter int NCHILD = 4,
  parameter int VLEN   = 8,
  parameter int W      = 4,
  parameter int FB     = 8,
  localparam int CW    = $clog2(NCHILD),
  localparam int EW    = $clog2(VLEN),
  localparam int AW    = W * NCHILD,
  localparam int OW    = FB + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          child_rd_en,
  output logic [CW-1:0] child_sel,
  output logic [EW-1:0] child_addr,
  input  logic [W-1:0]  child_data,
  output logic          pi_rd_en,
  output logic [EW-1:0] pi_addr,
  input  logic [W-1:0]  pi_data,
  output logic          lam_we,
  output logic [EW-1:0] lam_addr,
  output logic [AW-1:0] lam_data,
  output logic          out_we,
  output logic [CW-1:0] out_child,
  output logic [EW-1:0] out_addr,
  output logic [OW-1:0] out_data,
  output logic          done
);
  import cmb_pkg::*;

  localparam int SW    = AW + EW;
  localparam int NW    = AW + FB;
  localparam int DEPTH = NCHILD * VLEN;
  localparam int MW    = $clog2(DEPTH);
  localparam int KW    = $clog2(NCHILD + 2);
  localparam logic [KW-1:0] KEND = KW'(NCHILD + 1);
  localparam logic [EW-1:0] ELAST = EW'(VLEN - 1);
  localparam logic [CW-1:0] CLAST = CW'(NCHILD - 1);

  cmb_state_e    state;
  logic [CW-1:0] ch;
  logic [EW-1:0] el;
  logic [KW-1:0] k;
  logic          ld_v;
  logic [MW-1:0] ld_addr;
  logic          rv;
  logic [CW-1:0] rk;
  logic [AW-1:0] acc;
  logic [SW-1:0] sum;
  logic          div_go;
  logic          div_ok;
  logic [NW-1:0] quo;

  logic          term_issue;
  logic          in_calc;
  logic [MW-1:0] st_raddr;
  logic [MW-1:0] ld_next;
  logic [W-1:0]  st_q;
  logic [W-1:0]  factor;
  logic [AW-1:0] base;
  logic [AW-1:0] mul;

  assign child_rd_en = (state == ST_LOAD);
  assign child_sel   = ch;
  assign child_addr  = el;
  assign pi_rd_en    = ((state == ST_SUM) || (state == ST_DIVT)) && (k == '0);
  assign pi_addr     = el;

  assign in_calc    = (state == ST_DIAG) || (state == ST_SUM) || (state == ST_DIVT);
  assign term_issue = in_calc && (k < KW'(NCHILD));
  assign st_raddr   = MW'(k) * MW'(VLEN) + MW'(el);
  assign ld_next    = MW'(ch) * MW'(VLEN) + MW'(el);

  cmb_store #(.W(W), .DEPTH(DEPTH), .AB(MW)) u_store (
    .clk   (clk),
    .we    (ld_v),
    .waddr (ld_addr),
    .wdata (child_data),
    .re    (term_issue),
    .raddr (st_raddr),
    .rdata (st_q)
  );

  cmb_div #(.NW(NW), .DW(SW)) u_div (
    .clk (clk),
    .rst (rst),
    .go  (div_go),
    .num ({acc, FB'(0)}),
    .den (sum),
    .ok  (div_ok),
    .quo (quo)
  );

  // Exclude the target child's own term except in the diagnostic pass.
  assign factor = ((state == ST_DIAG) || (rk != ch)) ? st_q : W'(1);
  assign base   = (state == ST_DIAG) ? AW'(1) : AW'(pi_data);
  assign mul    = ((k == KW'(1)) ? base : acc) * AW'(factor);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ch        <= '0;
      el        <= '0;
      k         <= '0;
      ld_v      <= 1'b0;
      ld_addr   <= '0;
      rv        <= 1'b0;
      rk        <= '0;
      acc       <= '0;
      sum       <= '0;
      div_go    <= 1'b0;
      lam_we    <= 1'b0;
      lam_addr  <= '0;
      lam_data  <= '0;
      out_we    <= 1'b0;
      out_child <= '0;
      out_addr  <= '0;
      out_data  <= '0;
      done      <= 1'b0;
    end else begin
      lam_we <= 1'b0;
      out_we <= 1'b0;
      div_go <= 1'b0;
      ld_v   <= 1'b0;
      rv     <= term_issue;
      rk     <= CW'(k);
      if (rv) acc <= mul;

      unique case (state)
        ST_IDLE: begin
          if (start) begin
            done  <= 1'b0;
            ch    <= '0;
            el    <= '0;
            k     <= '0;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          ld_v    <= 1'b1;
          ld_addr <= ld_next;
          if (el == ELAST) begin
            el <= '0;
            if (ch == CLAST) begin
              ch    <= '0;
              k     <= '0;
              state <= ST_DIAG;
            end else begin
              ch <= ch + 1'b1;
            end
          end else begin
            el <= el + 1'b1;
          end
        end
        ST_DIAG, ST_SUM: begin
          if (k != KEND) begin
            k <= k + 1'b1;
          end else begin
            k <= '0;
            if (state == ST_DIAG) begin
              lam_we   <= 1'b1;
              lam_addr <= el;
              lam_data <= acc;
            end else begin
              sum <= sum + SW'(acc);
            end
            if (el == ELAST) begin
              el <= '0;
              if (state == ST_DIAG) begin
                sum   <= '0;
                state <= ST_SUM;
              end else begin
                state <= ST_DIVT;
              end
            end else begin
              el <= el + 1'b1;
            end
          end
        end
        ST_DIVT: begin
          if (k != KEND) begin
            k <= k + 1'b1;
          end else begin
            div_go <= 1'b1;
            state  <= ST_DWAIT;
          end
        end
        ST_DWAIT: begin
          if (div_ok) begin
            out_we    <= 1'b1;
            out_child <= ch;
            out_addr  <= el;
            out_data  <= (sum == '0) ? '0 : OW'(quo);
            k         <= '0;
            if (el == ELAST) begin
              el <= '0;
              if (ch == CLAST) begin
                state <= ST_FIN;
              end else begin
                ch    <= ch + 1'b1;
                sum   <= '0;
                state <= ST_SUM;
              end
            end else begin
              el    <= el + 1'b1;
              state <= ST_DIVT;
            end
          end
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmb_chk.sv
module cmb_chk #(
  parameter int NCHILD = 4,
  parameter int VLEN   = 8,
  parameter int CW     = 2,
  parameter int EW     = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          child_rd_en,
  input logic [CW-1:0] child_sel,
  input logic          lam_we,
  input logic          out_we,
  input logic [CW-1:0] out_child,
  input logic [EW-1:0] out_addr,
  input logic          done
);
  logic          rst_d;
  logic [CW-1:0] exp_ch;
  logic [EW-1:0] exp_el;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (!rst && rst_d) begin
      a_r1_reset_quiet: assert (!done && !lam_we && !out_we && !child_rd_en)
        else $error("R1 outputs active right after reset");
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_ch <= '0;
      exp_el <= '0;
    end else if (out_we) begin
      a_r5_order: assert (out_child == exp_ch && out_addr == exp_el)
        else $error("R5 outgoing element out of order");
      if (exp_el == EW'(VLEN - 1)) begin
        exp_el <= '0;
        exp_ch <= (exp_ch == CW'(NCHILD - 1)) ? '0 : exp_ch + 1'b1;
      end else begin
        exp_el <= exp_el + 1'b1;
      end
    end
  end

  a_r2_sel_range: assert property (@(posedge clk) disable iff (rst)
    child_rd_en |-> (int'(child_sel) < NCHILD));

  a_r2_bus_idle_on_write: assert property (@(posedge clk) disable iff (rst)
    child_rd_en |-> (!out_we && !lam_we));

  a_r6_busy_not_done: assert property (@(posedge clk) disable iff (rst)
    out_we |-> !done);

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(out_we) && $past(out_child) == CW'(NCHILD - 1)
                     && $past(out_addr) == EW'(VLEN - 1)));
endmodule

bind child_msg_combiner cmb_chk #(
  .NCHILD(NCHILD), .VLEN(VLEN), .CW(CW), .EW(EW)
) u_cmb_chk (
  .clk         (clk),
  .rst         (rst),
  .child_rd_en (child_rd_en),
  .child_sel   (child_sel),
  .lam_we      (lam_we),
  .out_we      (out_we),
  .out_child   (out_child),
  .out_addr    (out_addr),
  .done        (done)
);

// File: tb/child_msg_combiner_bench.sv
`timescale 1ns/1ps
module child_msg_combiner_bench;
  localparam int NCHILD = 4;
  localparam int VLEN   = 8;
  localparam int W      = 4;
  localparam int FB     = 8;
  localparam int CW     = $clog2(NCHILD);
  localparam int EW     = $clog2(VLEN);
  localparam int AW     = W * NCHILD;
  localparam int OW     = FB + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          clr = 1'b0;
  logic          child_rd_en;
  logic [CW-1:0] child_sel;
  logic [EW-1:0] child_addr;
  logic [W-1:0]  child_data = '0;
  logic          pi_rd_en;
  logic [EW-1:0] pi_addr;
  logic [W-1:0]  pi_data = '0;
  logic          lam_we;
  logic [EW-1:0] lam_addr;
  logic [AW-1:0] lam_data;
  logic          out_we;
  logic [CW-1:0] out_child;
  logic [EW-1:0] out_addr;
  logic [OW-1:0] out_data;
  logic          done;

  int total = 0;
  int bad   = 0;

  int unsigned cm  [NCHILD][VLEN];
  int unsigned pim [VLEN];
  int          rdcnt [NCHILD][VLEN];
  longint      got_lam [VLEN];
  longint      got_out [NCHILD][VLEN];
  int          nwr;

  always #2.5 clk = ~clk;

  child_msg_combiner #(.NCHILD(NCHILD), .VLEN(VLEN), .W(W), .FB(FB))
    u_child_msg_combiner (
    .clk(clk), .rst(rst), .start(start),
    .child_rd_en(child_rd_en), .child_sel(child_sel), .child_addr(child_addr),
    .child_data(child_data),
    .pi_rd_en(pi_rd_en), .pi_addr(pi_addr), .pi_data(pi_data),
    .lam_we(lam_we), .lam_addr(lam_addr), .lam_data(lam_data),
    .out_we(out_we), .out_child(out_child), .out_addr(out_addr),
    .out_data(out_data), .done(done)
  );

  // Synchronous source memories, one cycle of read latency.
  always @(posedge clk) begin
    if (child_rd_en) child_data <= W'(cm[child_sel][child_addr]);
    if (pi_rd_en) pi_data <= W'(pim[pi_addr]);
  end

  // Result capture and ordering check, sampled mid-cycle.
  int exp_c = 0;
  int exp_e = 0;
  always @(negedge clk) begin
    if (clr) begin
      for (int c = 0; c < NCHILD; c++)
        for (int e = 0; e < VLEN; e++) begin
          rdcnt[c][e] = 0; got_out[c][e] = -1;
        end
      for (int e = 0; e < VLEN; e++) got_lam[e] = -1;
      nwr = 0; exp_c = 0; exp_e = 0;
    end else if (!rst) begin
      if (child_rd_en) rdcnt[child_sel][child_addr]++;
      if (lam_we) got_lam[lam_addr] = longint'(lam_data);
      if (out_we) begin
        got_out[out_child][out_addr] = longint'(out_data);
        nwr++;
        total++;
        if (int'(out_child) != exp_c || int'(out_addr) != exp_e) begin
          bad++;
          $display("FAIL R5 order: got child %0d addr %0d, expected child %0d addr %0d",
                   out_child, out_addr, exp_c, exp_e);
        end
        if (exp_e == VLEN - 1) begin exp_e = 0; exp_c = (exp_c + 1) % NCHILD; end
        else exp_e++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Product of element e: excl<0 means all children without the causal term.
  function automatic longint prod(int excl, int e);
    longint p = (excl < 0) ? 1 : longint'(pim[e]);
    for (int c = 0; c < NCHILD; c++)
      if (c != excl) p = p * longint'(cm[c][e]);
    return p;
  endfunction

  task automatic run_case(input string name, input bit extra_start);
    int n;
    @(posedge clk); #1 start = 1'b1; clr = 1'b1;
    @(posedge clk); #1 start = 1'b0; clr = 1'b0;
    @(negedge clk);
    check(done == 1'b0, {"R6 done low after start ", name}, longint'(done), 0);
    if (extra_start) begin
      repeat (60) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    check(done == 1'b1, {"R6 done raised ", name}, longint'(done), 1);
    repeat (5) @(negedge clk);
    check(done == 1'b1, {"R6 done held ", name}, longint'(done), 1);
    begin
      int badc = 0;
      for (int c = 0; c < NCHILD; c++)
        for (int e = 0; e < VLEN; e++) if (rdcnt[c][e] != 1) badc++;
      check(badc == 0, {extra_start ? "R9 reads once with extra start " : "R2 reads once ", name},
            longint'(badc), 0);
    end
    check(nwr == NCHILD * VLEN, {"R9 write count ", name}, longint'(nwr), longint'(NCHILD * VLEN));
    for (int e = 0; e < VLEN; e++)
      check(got_lam[e] == prod(-1, e), {"R3 diagnostic ", name}, got_lam[e], prod(-1, e));
    for (int c = 0; c < NCHILD; c++) begin
      longint s = 0;
      longint tot = 0;
      for (int e = 0; e < VLEN; e++) s += prod(c, e);
      for (int e = 0; e < VLEN; e++) begin
        longint ex = (s == 0) ? 0 : (prod(c, e) << FB) / s;
        check(got_out[c][e] == ex, (s == 0) ? {"R7 zero sum ", name} : {"R4 outgoing ", name},
              got_out[c][e], ex);
        tot += got_out[c][e];
      end
      if (s != 0)
        check(tot <= (1 << FB) && tot >= (1 << FB) - VLEN, {"R8 normalized sum ", name},
              tot, longint'(1 << FB));
    end
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!done && !lam_we && !out_we && !child_rd_en, "R1 reset state",
          longint'({done, lam_we, out_we, child_rd_en}), 0);

    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < NCHILD; c++)
        for (int e = 0; e < VLEN; e++) cm[c][e] = $urandom_range(0, (1 << W) - 1);
      for (int e = 0; e < VLEN; e++) pim[e] = $urandom_range(1, (1 << W) - 1);
      run_case("random", r == 1);
    end

    for (int c = 0; c < NCHILD; c++)
      for (int e = 0; e < VLEN; e++) cm[c][e] = (1 << W) - 1;
    for (int e = 0; e < VLEN; e++) pim[e] = (1 << W) - 1;
    run_case("saturated", 1'b0);

    for (int c = 0; c < NCHILD; c++)
      for (int e = 0; e < VLEN; e++) cm[c][e] = (c == 0) ? 0 : $urandom_range(1, (1 << W) - 1);
    run_case("child0 zero", 1'b0);

    for (int c = 0; c < NCHILD; c++)
      for (int e = 0; e < VLEN; e++) cm[c][e] = $urandom_range(1, (1 << W) - 1);
    for (int e = 0; e < VLEN; e++) pim[e] = 0;
    run_case("causal zero", 1'b0);

    for (int e = 0; e < VLEN; e++) pim[e] = (e == 3) ? 7 : 0;
    run_case("single nonzero", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule